// File: doc/BRIEF.md
# Lockable Secure Scratch Register Bank

This block holds a small bank of 32-bit scratch words that only a secure master may touch. The words are split into groups of four consecutive words, so each group carries one 128-bit value, for example a key seed or a message authentication tag. Every group has two one-way locks. The write lock freezes the stored contents. The read lock hides them. A dedicated lock command port sets each lock, and only a reset clears it.

Software uses a fixed sequence. It writes the four words of a group, sets the write lock, and reads the words back to confirm that they are correct. It then sets the read lock. Between the two lock steps the readback still works, so the value can be checked before it is hidden. A status query port reports, per group, whether the group is fully locked, open, or only half locked.

Top module: `ssr_bank`

## Requirements
- R1: After reset both locks of every group are clear, the status of every group reads 1, `rd_valid` and `rd_data` are 0, and the stored words keep their contents across a reset.
- R2: Every read request gets `rd_valid` high exactly one cycle later. For a permitted read, `rd_data` in that cycle holds the stored word.
- R3: Word address `a` belongs to group `a / 4` (group index in the upper address bits, word index in the two lowest). With defaults, addresses 0 to 3 form group 0 and addresses 4 to 7 form group 1.
- R4: A write to a word of a write-locked group is dropped, and the stored value stays unchanged.
- R5: When a group is write-locked but not read-locked, reads still return the stored words.
- R6: A read of a word in a read-locked group returns 0. `rd_valid` still pulses.
- R7: The status code for a group is 0 when both locks are set, 1 when neither is set, and 2 when exactly one is set. Code 3 never appears. `st_code` shows the state of group `st_group` one cycle after it is selected.
- R8: Locks are sticky. A repeated lock command changes nothing, and only reset clears a lock. A write issued in the same cycle as its group's write-lock command is still accepted.
- R9: When `secure_i` is low, the block ignores writes and lock commands, and reads return 0.
- R10: Locks act per group. Locking one group leaves reads and writes of every other group unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| secure_i | input | 1 | High when the current access or command is secure |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (3) | Word address, {group, word} |
| req_wdata | input | DATA_W (32) | Write data |
| rd_valid | output | 1 | Read response, one cycle after a read request |
| rd_data | output | DATA_W (32) | Read data, or 0 when the read is refused |
| lk_valid | input | 1 | Lock command strobe |
| lk_group | input | GRP_W (1) | Group that the lock command targets |
| lk_read | input | 1 | 1 = set the read lock, 0 = set the write lock |
| st_group | input | GRP_W (1) | Group selected for the status query |
| st_code | output | 2 | Combined lock status of the selected group |

## Verification
The bench builds the block with its default parameters: two groups of four 32-bit words. This makes the address space small enough that random traffic reaches every word many times. It also lets one group be driven into the partial state while the other is driven into the full locked state, so that all three status codes appear side by side. Random secure and non-secure reads and writes run once before any lock is set and once after both groups are locked in different ways. A final reset confirms that the locks clear while the stored contents remain.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic [1:0] {
    LS_LOCKED  = 2'd0,
    LS_OPEN    = 2'd1,
    LS_PARTIAL = 2'd2
  } lock_state_e;

  function automatic lock_state_e lock_code(input logic wl, input logic rl);
    if (wl && rl)      return LS_LOCKED;
    else if (wl || rl) return LS_PARTIAL;
    else               return LS_OPEN;
  endfunction
endpackage

// File: rtl/ssr_lock_ctrl.sv
module ssr_lock_ctrl
  import ssr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        set_wr,
  input  logic        set_rd,
  output logic        wr_locked,
  output logic        rd_locked,
  output lock_state_e state
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_locked <= 1'b0;
      rd_locked <= 1'b0;
    end else begin
      if (set_wr) wr_locked <= 1'b1;
      if (set_rd) rd_locked <= 1'b1;
    end
  end

  assign state = lock_code(wr_locked, rd_locked);
endmodule

// File: rtl/ssr_word_store.sv
module ssr_word_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ssr_bank.sv
module ssr_bank
  import ssr_pkg::*;
#(
  parameter int NUM_GROUPS      = 2,
  parameter int WORDS_PER_GROUP = 4,
  parameter int DATA_W          = 32,
  localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int WRD_W  = (WORDS_PER_GROUP > 1) ? $clog2(WORDS_PER_GROUP) : 1,
  localparam int ADDR_W = GRP_W + WRD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              secure_i,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              lk_valid,
  input  logic [GRP_W-1:0]  lk_group,
  input  logic              lk_read,
  input  logic [GRP_W-1:0]  st_group,
  output logic [1:0]        st_code
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [NUM_GROUPS-1:0] wlock_v;
  logic [NUM_GROUPS-1:0] rlock_v;
  lock_state_e           state_v [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic cmd_hit;
    assign cmd_hit = lk_valid && secure_i && (int'(lk_group) == g);
    ssr_lock_ctrl u_lock (
      .clk      (clk),
      .rst      (rst),
      .set_wr   (cmd_hit && !lk_read),
      .set_rd   (cmd_hit && lk_read),
      .wr_locked(wlock_v[g]),
      .rd_locked(rlock_v[g]),
      .state    (state_v[g])
    );
  end

  logic [GRP_W-1:0] req_grp;
  logic             req_in_range;
  logic             acc_ok;
  logic             grp_wlocked;
  logic             grp_rlocked;
  logic             wr_en;
  logic             rd_req;
  logic             rd_gate_d;
  logic             rd_gate_q;
  logic [DATA_W-1:0] store_q;

  assign req_grp      = req_addr[ADDR_W-1 -: GRP_W];
  assign req_in_range = int'(req_grp) < NUM_GROUPS;
  assign acc_ok       = req_valid && secure_i && req_in_range;

  always_comb begin
    grp_wlocked = 1'b1;
    grp_rlocked = 1'b1;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (int'(req_grp) == g) begin
        grp_wlocked = wlock_v[g];
        grp_rlocked = rlock_v[g];
      end
    end
  end

  assign wr_en     = acc_ok && req_write && !grp_wlocked;
  assign rd_req    = req_valid && !req_write;
  assign rd_gate_d = acc_ok && !req_write && !grp_rlocked;

  ssr_word_store #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_store (
    .clk  (clk),
    .we   (wr_en),
    .waddr(req_addr),
    .wdata(req_wdata),
    .re   (rd_req),
    .raddr(req_addr),
    .rdata(store_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_gate_q <= 1'b0;
    end else begin
      rd_valid  <= rd_req;
      rd_gate_q <= rd_gate_d;
    end
  end

  assign rd_data = rd_gate_q ? store_q : '0;

  lock_state_e st_sel;
  always_comb begin
    st_sel = LS_OPEN;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (int'(st_group) == g) st_sel = state_v[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_code <= LS_OPEN;
    else     st_code <= st_sel;
  end
endmodule

// File: rtl/ssr_bank_chk.sv
module ssr_bank_chk #(
  parameter int NUM_GROUPS      = 2,
  parameter int WORDS_PER_GROUP = 4,
  parameter int DATA_W          = 32,
  localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int WRD_W  = (WORDS_PER_GROUP > 1) ? $clog2(WORDS_PER_GROUP) : 1,
  localparam int ADDR_W = GRP_W + WRD_W
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  secure_i,
  input logic                  req_valid,
  input logic                  req_write,
  input logic [ADDR_W-1:0]     req_addr,
  input logic                  rd_valid,
  input logic [DATA_W-1:0]     rd_data,
  input logic [1:0]            st_code,
  input logic [NUM_GROUPS-1:0] wlock_v,
  input logic [NUM_GROUPS-1:0] rlock_v
);
  logic [GRP_W-1:0] a_grp;
  logic             a_rlocked;
  assign a_grp = req_addr[ADDR_W-1 -: GRP_W];

  always_comb begin
    a_rlocked = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (int'(a_grp) == g) a_rlocked = rlock_v[g];
    end
  end

  // R2
  rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rd_valid);

  // R6
  rlocked_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && a_rlocked) |=> (rd_data == '0));

  // R9
  nonsecure_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !secure_i) |=> (rd_data == '0));

  // R7
  status_code_chk: assert property (@(posedge clk) disable iff (rst)
    st_code != 2'd3);

  // R8
  wlock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((wlock_v & $past(wlock_v)) == $past(wlock_v)));

  // R8
  rlock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rlock_v & $past(rlock_v)) == $past(rlock_v)));
endmodule

bind ssr_bank ssr_bank_chk #(
  .NUM_GROUPS     (NUM_GROUPS),
  .WORDS_PER_GROUP(WORDS_PER_GROUP),
  .DATA_W         (DATA_W)
) u_ssr_bank_chk (
  .clk      (clk),
  .rst      (rst),
  .secure_i (secure_i),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .st_code  (st_code),
  .wlock_v  (wlock_v),
  .rlock_v  (rlock_v)
);

// File: tb/test_ssr_bank.sv
`timescale 1ns/1ps
module test_ssr_bank;
  localparam int NG = 2;
  localparam int NW = 4;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int NWORDS = NG * NW;

  logic          clk = 1'b0;
  logic          rst;
  logic          secure_i;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          lk_valid;
  logic [0:0]    lk_group;
  logic          lk_read;
  logic [0:0]    st_group;
  logic [1:0]    st_code;

  always #2.5 clk = ~clk;

  ssr_bank i_ssr_bank (
    .clk(clk), .rst(rst), .secure_i(secure_i),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .lk_valid(lk_valid), .lk_group(lk_group), .lk_read(lk_read),
    .st_group(st_group), .st_code(st_code)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [DW-1:0] m_mem [NWORDS];
  logic          m_wl  [NG];
  logic          m_rl  [NG];

  function automatic logic [1:0] exp_code(input logic w, input logic r);
    if (w && r) return 2'd0;
    if (w || r) return 2'd2;
    return 2'd1;
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a, input logic sec);
    if (!sec || m_rl[a / NW]) return '0;
    return m_mem[a];
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_write = 0; lk_valid = 0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic sec);
    @(negedge clk);
    secure_i = sec; req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    if (sec && !m_wl[a / NW]) m_mem[a] = d;
    @(negedge clk);
    idle();
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic sec, input string req);
    logic [DW-1:0] e;
    @(negedge clk);
    secure_i = sec; req_valid = 1; req_write = 0; req_addr = a;
    e = exp_read(a, sec);
    @(negedge clk);
    idle();
    check(rd_valid === 1'b1, "R2", {31'd0, rd_valid}, 32'd1);
    check(rd_data === e, req, rd_data, e);
  endtask

  task automatic do_lock(input int g, input logic rd, input logic sec);
    @(negedge clk);
    secure_i = sec; lk_valid = 1; lk_group = g[0]; lk_read = rd;
    if (sec) begin
      if (rd) m_rl[g] = 1; else m_wl[g] = 1;
    end
    @(negedge clk);
    idle();
  endtask

  task automatic query(input int g, input string req);
    logic [1:0] e;
    @(negedge clk);
    st_group = g[0];
    e = exp_code(m_wl[g], m_rl[g]);
    @(negedge clk);
    check(st_code === e, req, {30'd0, st_code}, {30'd0, e});
  endtask

  task automatic rand_phase(input int n);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      logic sec;
      a   = AW'($urandom_range(NWORDS - 1));
      sec = ($urandom_range(9) < 8);
      if ($urandom_range(1) == 1) do_write(a, $urandom, sec);
      else do_read(a, sec, sec ? "R3" : "R9");
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0001));
    for (int i = 0; i < NWORDS; i++) m_mem[i] = '0;
    for (int g = 0; g < NG; g++) begin m_wl[g] = 0; m_rl[g] = 0; end
    rst = 1; secure_i = 0; idle(); req_addr = '0; req_wdata = '0;
    lk_group = '0; lk_read = 0; st_group = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(rd_valid === 1'b0, "R1", {31'd0, rd_valid}, 32'd0);
    check(rd_data === '0, "R1", rd_data, 32'd0);
    query(0, "R1");
    query(1, "R1");

    // fill all words, then random traffic before locks
    for (int a = 0; a < NWORDS; a++) do_write(AW'(a), 32'hA000_0000 + a, 1);
    for (int a = 0; a < NWORDS; a++) do_read(AW'(a), 1, "R3");
    rand_phase(200);

    // R9 non-secure write dropped, read zero
    do_write(3'd1, 32'hDEAD_BEEF, 0);
    do_read(3'd1, 1, "R9");
    do_read(3'd1, 0, "R9");

    // group 0 key sequence
    for (int a = 0; a < NW; a++) do_write(AW'(a), 32'h1111_0000 + a, 1);
    do_lock(0, 0, 1);
    query(0, "R7");
    query(1, "R10");
    // R4 write dropped; R5 readback still valid
    do_write(3'd2, 32'h0BAD_0BAD, 1);
    for (int a = 0; a < NW; a++) do_read(AW'(a), 1, "R5");
    // R10 group 1 still writable
    do_write(3'd5, 32'h2222_5555, 1);
    do_read(3'd5, 1, "R10");
    do_read(3'd2, 1, "R4");

    // R9 non-secure lock command ignored
    do_lock(1, 1, 0);
    query(1, "R9");
    do_read(3'd5, 1, "R9");

    // R6 read lock group 0
    do_lock(0, 1, 1);
    query(0, "R7");
    do_read(3'd0, 1, "R6");
    do_read(3'd3, 1, "R6");
    // R8 repeat lock no change
    do_lock(0, 1, 1);
    do_lock(0, 0, 1);
    query(0, "R8");

    // R8 write together with write-lock command is accepted
    @(negedge clk);
    secure_i = 1; req_valid = 1; req_write = 1; req_addr = 3'd6;
    req_wdata = 32'h6666_6666; lk_valid = 1; lk_group = 1'b1; lk_read = 0;
    m_mem[6] = 32'h6666_6666; m_wl[1] = 1;
    @(negedge clk);
    idle();
    do_read(3'd6, 1, "R8");
    query(1, "R7");

    // random traffic with locks in place
    rand_phase(200);
    do_read(3'd7, 1, "R10");

    // reset clears locks, contents retained
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int g = 0; g < NG; g++) begin m_wl[g] = 0; m_rl[g] = 0; end
    query(0, "R8");
    query(1, "R1");
    do_read(3'd0, 1, "R1");
    do_read(3'd6, 1, "R1");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule